// File: doc/BRIEF.md
# Four-Wire Serial Target with Fault and Overrun Detection

This block is the target side of a four-wire synchronous serial link. An external controller drives the serial clock, a select line and the data line into the block. The block returns data on its own output line, which is enabled only while select is active. Words received from the controller go into a receive queue. Words to be returned are taken from a transmit queue that local logic fills. The link timing mode (clock idle level and sampling phase), the bit order, the word length (8, 16 or 32 bits) and the active level of select are set through static configuration inputs. These inputs are expected to change only while select is inactive.

All link inputs pass through two-flop synchronizers and are sampled in the system clock domain. The serial clock must therefore run at no more than one quarter of the system clock. The controller must also leave at least two system clock cycles between asserting select and its first clock edge. One state machine with the states `ST_IDLE`, `ST_LOAD` and `ST_SHIFT` frames each word:
- `ST_IDLE` moves to `ST_LOAD` when select becomes active.
- `ST_LOAD` latches the configuration and the head of the transmit queue. It moves to `ST_SHIFT`, or back to `ST_IDLE` if select has already dropped.
- `ST_SHIFT` counts sampling edges. It moves to `ST_LOAD` on the sampling edge that completes a word, and to `ST_IDLE` when select is negated. A negation that cuts a partly shifted word is reported as a fault.

A transmit entry is consumed only when its word completes. A word that arrives while the receive queue is full is dropped and reported. Three interrupt lines, each with its own enable, report receive data available, transmit queue empty, and a sticky error.

Top module: `spi_target`

## Requirements
- R1: After reset both queues are empty, both error flags are 0, the data output enable is 0 while select is inactive, and `irq_rx` and `irq_err` are 0.
- R2: `cfg_cpol` sets the clock idle level and `cfg_cpha` sets the phase. Incoming data is sampled on the rising clock edge when `cfg_cpol == cfg_cpha`, and on the falling edge otherwise. Words exchange correctly in all four modes.
- R3: `cfg_len` selects the word length: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 or 2'b11 = 32 bits. Received words are right-justified in `rx_data`, and the unused upper bits are 0. Only the low bits of a transmit word are sent.
- R4: With `cfg_lsb_first = 1` bit 0 travels first, otherwise bit (length-1) travels first. The same order applies in both directions.
- R5: The data output carries the transmit queue head, latched when the word starts. If the queue is empty, the output carries all zeros. Several words may follow one another under a single select assertion.
- R6: With `cfg_sel_high = 1` select is active when high, otherwise when low. Clock edges while select is inactive have no effect.
- R7: `spi_miso_oe` is 1 exactly while the synchronized select is active.
- R8: Select negated after at least one, but fewer than all, bits of a word sets `modf_flag` and discards the partial word. The transmit entry is not consumed. Select negated before any bit sets no flag.
- R9: A word completed while the receive queue is full sets `ovr_flag`. The word is dropped and the queued contents are kept.
- R10: `modf_flag` and `ovr_flag` stay set until a one-cycle `err_clr` pulse clears both.
- R11: `irq_rx` = receive queue not empty AND `irq_en_rx`. `irq_tx` = transmit queue empty AND `irq_en_tx`. `irq_err` = (`modf_flag` OR `ovr_flag`) AND `irq_en_err`.
- R12: The receive queue holds 8 words and the transmit queue holds 2 words, both in first-in first-out order. A write to a full transmit queue is ignored, as is a read from an empty receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from controller |
| spi_sel | input | 1 | Select from controller |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out driver |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_len | input | 2 | Word length code |
| cfg_sel_high | input | 1 | 1 = select active high |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 32 | Transmit word |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the receive queue head |
| rx_data | output | 32 | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| err_clr | input | 1 | Clear both error flags |
| modf_flag | output | 1 | Sticky mid-word select-loss flag |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| irq_en_rx | input | 1 | Receive interrupt enable |
| irq_en_tx | input | 1 | Transmit interrupt enable |
| irq_en_err | input | 1 | Error interrupt enable |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The embedded properties check several things on every cycle:
- the bit counter never reaches the latched word length;
- a mid-word select loss always returns the machine to idle;
- a dropped overrun word never disturbs a full receive queue;
- the error flags hold until cleared;
- queue occupancy stays bounded and is unchanged by a write to a full queue.

Bit ordering, sampling-edge choice, right-justification, select polarity, retention of the transmit entry after a fault, and first-in first-out content can only be shown end to end. For these, the bench sweeps every mode, length and order with arithmetically generated words, and runs directed fault and overrun scenarios.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int CNT_W  = IDX_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_t;

    // word length code to bit count: 00 -> 8, 01 -> 16, others -> 32
    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
        unique case (code)
            2'b00:   word_bits = CNT_W'(8);
            2'b01:   word_bits = CNT_W'(16);
            default: word_bits = CNT_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_tgt_fifo.sv
module spi_tgt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R12: occupancy bounded by depth
    p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R12: a write into a full queue without a read leaves occupancy unchanged
    p_full_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_act,
    input  logic              mosi_s,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [1:0]        cfg_len,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              tx_avail,
    input  logic              rx_full,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              miso_bit,
    output logic              modf_pulse,
    output logic              ovr_pulse
);
    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, len_q, idx_full;
    logic [WORD_W-1:0] tx_word_q, rx_word_q, rx_ins;
    logic              took_q, lsb_q, rise_samp_q, sclk_d;
    logic              samp_edge, last_bit, word_done;

    // edge detection in the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign samp_edge = rise_samp_q ? (sclk_s && !sclk_d) : (!sclk_s && sclk_d);
    assign last_bit  = (cnt_q == len_q - 1'b1);
    assign word_done = (state_q == ST_SHIFT) && sel_act && samp_edge && last_bit;
    assign idx_full  = lsb_q ? cnt_q : (len_q - 1'b1 - cnt_q);

    always_comb begin
        rx_ins = rx_word_q;
        rx_ins[idx_full[IDX_W-1:0]] = mosi_s;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_act) state_d = ST_LOAD;
            ST_LOAD:  state_d = sel_act ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: begin
                if (!sel_act)      state_d = ST_IDLE;
                else if (word_done) state_d = ST_LOAD;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        ovr_pulse  = 1'b0;
        modf_pulse = 1'b0;
        miso_bit   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD: ;
            ST_SHIFT: begin
                miso_bit   = tx_word_q[idx_full[IDX_W-1:0]];
                tx_pop     = word_done && took_q;
                rx_push    = word_done && !rx_full;
                ovr_pulse  = word_done && rx_full;
                modf_pulse = !sel_act && (cnt_q != '0);
            end
            default: ;
        endcase
    end

    assign rx_word = rx_ins;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            len_q       <= CNT_W'(8);
            tx_word_q   <= '0;
            rx_word_q   <= '0;
            took_q      <= 1'b0;
            lsb_q       <= 1'b0;
            rise_samp_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    cnt_q       <= '0;
                    rx_word_q   <= '0;
                    len_q       <= word_bits(cfg_len);
                    lsb_q       <= cfg_lsb_first;
                    rise_samp_q <= (cfg_cpol == cfg_cpha);
                    took_q      <= tx_avail;
                    tx_word_q   <= tx_avail ? tx_head : '0;
                end
                ST_SHIFT: begin
                    if (sel_act && samp_edge && !last_bit) begin
                        rx_word_q <= rx_ins;
                        cnt_q     <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // R3: the bit counter stays inside the latched word length
    p_cnt_in_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (cnt_q < len_q));

    // R8: a mid-word select loss always returns the machine to idle
    p_fault_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        modf_pulse |=> (state_q == ST_IDLE));

    // R5: word completion always re-enters the load state
    p_done_reloads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (state_q == ST_LOAD));
endmodule

// File: rtl/spi_target.sv
module spi_target
    import spi_tgt_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 2,
    parameter int SYNC_STG = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_sel,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        cfg_lsb_first,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_sel_high,
    input  logic        tx_wr,
    input  logic [31:0] tx_data,
    output logic        tx_full,
    input  logic        rx_rd,
    output logic [31:0] rx_data,
    output logic        rx_empty,
    input  logic        err_clr,
    output logic        modf_flag,
    output logic        ovr_flag,
    input  logic        irq_en_rx,
    input  logic        irq_en_tx,
    input  logic        irq_en_err,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        irq_err
);
    logic [2:0]        link_s;
    logic              sel_act;
    logic [WORD_W-1:0] tx_head, rx_word;
    logic              tx_empty, rx_full;
    logic              tx_pop, rx_push, modf_pulse, ovr_pulse;
    logic              modf_q, ovr_q;

    spi_tgt_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_sel, spi_mosi}),
        .q     (link_s)
    );

    assign sel_act = cfg_sel_high ? link_s[1] : !link_s[1];

    spi_tgt_engine u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_s        (link_s[2]),
        .sel_act       (sel_act),
        .mosi_s        (link_s[0]),
        .cfg_cpol      (cfg_cpol),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_len       (cfg_len),
        .tx_head       (tx_head),
        .tx_avail      (!tx_empty),
        .rx_full       (rx_full),
        .tx_pop        (tx_pop),
        .rx_push       (rx_push),
        .rx_word       (rx_word),
        .miso_bit      (spi_miso),
        .modf_pulse    (modf_pulse),
        .ovr_pulse     (ovr_pulse)
    );

    spi_tgt_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .din   (tx_data),
        .pop   (tx_pop),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_tgt_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rx_rd),
        .dout  (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            modf_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (modf_pulse)   modf_q <= 1'b1;
            else if (err_clr) modf_q <= 1'b0;
            if (ovr_pulse)    ovr_q  <= 1'b1;
            else if (err_clr) ovr_q  <= 1'b0;
        end
    end

    assign modf_flag   = modf_q;
    assign ovr_flag    = ovr_q;
    assign spi_miso_oe = sel_act;
    assign irq_rx      = !rx_empty && irq_en_rx;
    assign irq_tx      = tx_empty && irq_en_tx;
    assign irq_err     = (modf_q || ovr_q) && irq_en_err;

    // R9: a dropped overrun word leaves a full receive queue full
    p_ovr_keeps_queue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_pulse && !rx_rd) |=> rx_full);

    // R10: error flags hold until cleared
    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((modf_q || ovr_q) && !err_clr) |=> (modf_q || ovr_q));

    // R8: select loss mid-word never writes the receive queue
    p_fault_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        modf_pulse |-> !rx_push);
endmodule

// File: tb/sim_spi_target.sv
module sim_spi_target;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_sel = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_sel_high = 1'b1;
    logic [1:0]  cfg_len = 2'b00;
    logic        tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_full, rx_empty, modf_flag, ovr_flag;
    logic [31:0] rx_data;
    logic        irq_en_rx = 1'b0, irq_en_tx = 1'b1, irq_en_err = 1'b0;
    logic        irq_rx, irq_tx, irq_err;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    spi_target u0 (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lmask(input logic [1:0] code);
        lmask = (code == 2'b00) ? 32'h0000_00FF : (code == 2'b01) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int lbits(input logic [1:0] code);
        lbits = (code == 2'b00) ? 8 : (code == 2'b01) ? 16 : 32;
    endfunction

    task automatic configure(input logic cpol, input logic cpha, input logic lsb,
                             input logic [1:0] len, input logic selh);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_len = len; cfg_sel_high = selh;
        spi_sel = !selh; spi_sclk = cpol;
        tick(6);
    endtask

    task automatic push_tx(input logic [31:0] w);
        tx_data = w; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask

    task automatic pop_rx(output logic [31:0] w);
        w = rx_data; rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
    endtask

    task automatic sel_on;
        spi_sel = cfg_sel_high; tick(4);
    endtask

    task automatic sel_off;
        tick(HALF); spi_sel = !cfg_sel_high; tick(6);
    endtask

    task automatic shift_word(input int n, input logic [31:0] md, output logic [31:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : n - 1 - i;
            if (!cfg_cpha) begin
                spi_mosi = md[idx];
                tick(HALF);
                got[idx] = spi_miso;
                spi_sclk = !cfg_cpol;
                tick(HALF);
                spi_sclk = cfg_cpol;
            end else begin
                spi_sclk = !cfg_cpol;
                spi_mosi = md[idx];
                tick(HALF);
                got[idx] = spi_miso;
                spi_sclk = cfg_cpol;
                tick(HALF);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] got, rd, txw, mdw;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        chk("R1 oe", {31'b0, spi_miso_oe}, 32'd0);
        chk("R1 rx_empty", {31'b0, rx_empty}, 32'd1);
        chk("R1 tx_full", {31'b0, tx_full}, 32'd0);
        chk("R1 flags", {30'b0, modf_flag, ovr_flag}, 32'd0);
        chk("R1 irq_rx/err", {30'b0, irq_rx, irq_err}, 32'd0);
        chk("R11 irq_tx empty", {31'b0, irq_tx}, 32'd1);

        // R2 R3 R4 R6 sweep of modes, lengths and orders
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 3; l++) begin
                for (int b = 0; b < 2; b++) begin
                    int k;
                    k = m * 6 + l * 2 + b;
                    txw = 32'h9E37_79B9 * (k + 1);
                    mdw = 32'hC2B2_AE35 ^ (32'h0101_0101 * k);
                    configure(m[1], m[0], b[0], l[1:0], (m != 2));
                    push_tx(txw);
                    sel_on;
                    chk("R7 oe active", {31'b0, spi_miso_oe}, 32'd1);
                    shift_word(lbits(l[1:0]), mdw, got);
                    sel_off;
                    chk("R2/R3/R4 miso word", got, txw & lmask(l[1:0]));
                    pop_rx(rd);
                    chk("R2/R3/R4/R6 rx word", rd, mdw & lmask(l[1:0]));
                end
            end
        end

        // R5: two words under one select, second from queue; then empty queue sends zero
        configure(1'b0, 1'b1, 1'b0, 2'b01, 1'b0);
        push_tx(32'h0000_1234);
        push_tx(32'h0000_ABCD);
        sel_on;
        shift_word(16, 32'h0000_5A5A, got);
        chk("R5 first word", got, 32'h0000_1234);
        shift_word(16, 32'h0000_C3C3, got);
        chk("R5 second word", got, 32'h0000_ABCD);
        shift_word(16, 32'h0000_0F0F, got);
        chk("R5 empty queue zeros", got, 32'h0);
        sel_off;
        pop_rx(rd); chk("R5 rx 1", rd, 32'h5A5A);
        pop_rx(rd); chk("R5 rx 2", rd, 32'h C3C3);
        pop_rx(rd); chk("R5 rx 3", rd, 32'h0F0F);

        // R6/R7: select inactive (active-high, held low) ignores clock edges
        configure(1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
        shift_word(8, 32'hFF, got);
        tick(6);
        chk("R6 ignored rx_empty", {31'b0, rx_empty}, 32'd1);
        chk("R7 oe inactive", {31'b0, spi_miso_oe}, 32'd0);

        // R8: mid-word select loss
        irq_en_err = 1'b1;
        push_tx(32'h0000_00B6);
        sel_on;
        shift_word(3, 32'h0000_00E0, got);
        sel_off;
        chk("R8 modf set", {31'b0, modf_flag}, 32'd1);
        chk("R8 partial discarded", {31'b0, rx_empty}, 32'd1);
        chk("R11 irq_err", {31'b0, irq_err}, 32'd1);
        tick(10);
        chk("R10 modf sticky", {31'b0, modf_flag}, 32'd1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
        chk("R10 modf cleared", {31'b0, modf_flag}, 32'd0);
        sel_on; sel_off;
        chk("R8 zero-bit no fault", {31'b0, modf_flag}, 32'd0);
        sel_on;
        shift_word(8, 32'h0000_0011, got);
        sel_off;
        chk("R8 tx entry retained", got, 32'h0000_00B6);
        pop_rx(rd);

        // R9: overrun after eight stored words; R11 irq_rx and mask; R12 order
        irq_en_rx = 1'b1;
        for (int i = 0; i < 9; i++) begin
            sel_on;
            shift_word(8, (i * 17 + 3) & 32'hFF, got);
            sel_off;
        end
        chk("R9 ovr set", {31'b0, ovr_flag}, 32'd1);
        chk("R11 irq_rx", {31'b0, irq_rx}, 32'd1);
        irq_en_rx = 1'b0; tick(1);
        chk("R11 irq_rx masked", {31'b0, irq_rx}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            pop_rx(rd);
            chk("R9/R12 kept contents", rd, (i * 17 + 3) & 32'hFF);
        end
        chk("R9 dropped word", {31'b0, rx_empty}, 32'd1);
        pop_rx(rd);
        chk("R12 read empty ignored", {31'b0, rx_empty}, 32'd1);
        chk("R10 ovr sticky", {31'b0, ovr_flag}, 32'd1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
        chk("R10 ovr cleared", {31'b0, ovr_flag}, 32'd0);
        chk("R11 irq_err clear", {31'b0, irq_err}, 32'd0);

        // R12: transmit queue holds two; third write ignored
        push_tx(32'h11); push_tx(32'h22); push_tx(32'h33);
        chk("R12 tx_full", {31'b0, tx_full}, 32'd1);
        chk("R11 irq_tx not empty", {31'b0, irq_tx}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            sel_on;
            shift_word(8, 32'h0, got);
            sel_off;
            chk("R12 tx order", got, (i == 0) ? 32'h11 : (i == 1) ? 32'h22 : 32'h0);
            pop_rx(rd);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule